// File: doc/BRIEF.md
# Transfer Unit Stuffing Packer

This block sits on one lane of a display link transmitter, between a source of packed pixel bytes and the scrambler. Every symbol clock it produces one 8-bit symbol plus a flag that marks control characters. Within a video line it cuts the link time into transfer units of a configured, constant length. Each unit starts with payload bytes taken from the source and finishes with a stuffing run: an FS control code, zero bytes, and an FE control code in the unit's last slot.

The number of payload bytes allowed into each unit follows a fixed-point fill ratio, given as an integer part and a 16-bit fraction. A phase accumulator adds the fraction once per unit, and each carry grants that unit one extra byte. Over many units the payload rate therefore tracks the non-integer target. If the source runs dry partway through a unit, the unit switches to stuffing early and the missing bytes are owed to the next unit. A line opens with a BE control code and closes with a BS control code right after its last byte, so the final unit of a line is cut short.

Top module: `tu_stuff_packer`

## Requirements
- R1: Outside a line the output is the non-control byte 0x00 on every cycle, and symbols offered without the line-start flag are accepted (in_ready high) and discarded.
- R2: A symbol offered with in_sol while idle is not taken in that cycle; the next output is BE (control, 0xFB), and that symbol becomes the first payload byte of the first unit.
- R3: Every complete unit is exactly cfg_tu_len symbols long and its last slot carries FE (control, 0xF7).
- R4: Inside a unit, payload bytes come first, then FS (control, 0xFE), then non-control 0x00 bytes up to the FE.
- R5: Each accepted byte appears as a non-control output one cycle after its handshake, in arrival order.
- R6: With a source that never stalls, unit k of a line (k from 1) carries cfg_fill_int + c_k payload bytes, where c_k is 1 exactly when floor(k*frac/65536) exceeds floor((k-1)*frac/65536).
- R7: A unit never carries more than cfg_tu_len-2 payload bytes, so FS and FE always fit; when the limit is reached they are sent back to back in the last two slots, and the excess is owed to the next unit.
- R8: If in_valid is low while a unit still has room for payload, FS is sent in that slot, and the bytes not sent are added to the next unit's allowance (owed total capped at 64).
- R9: After the byte flagged in_eol, the next output is BS (control, 0xBC), the current unit ends there, and the block returns to idle; the phase and the owed count restart from zero at each line start.
- R10: After reset the output is non-control 0x00 and in_ready is high while in_sol is low.
- R11: in_ready is low during stuffing and during the BS cycle, and within the payload part it is high only while the unit's allowance is not used up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Packed payload byte |
| in_valid | input | 1 | Payload byte offered |
| in_ready | output | 1 | Payload byte accepted this cycle when in_valid is high |
| in_sol | input | 1 | Offered byte is the first of a line |
| in_eol | input | 1 | Offered byte is the last of a line |
| cfg_tu_len | input | 7 | Unit length in symbols (32 to 64), held during a line |
| cfg_fill_int | input | 7 | Integer part of payload bytes per unit |
| cfg_fill_frac | input | 16 | Fractional part of payload bytes per unit, in 1/65536 |
| out_sym | output | 8 | Link symbol |
| out_is_k | output | 1 | Link symbol is a control character |

## Verification
On every cycle the assertions check that an accepted byte reappears unchanged one cycle later, that in_ready stays low while stuffing or closing a line, that FE only follows FS or a stuffing zero and always lands where the unit counter wraps, that the allowance never exceeds the unit length minus two, and that BS returns the block to idle. The per-unit payload counts that follow from the fractional phase, the carry of a stall deficit into the next unit, the clamp with back-to-back FS and FE, and the restart of the phase at each line can only be shown by the bench's line scenarios, which compare every unit's count against a count derived from the ratio.

// File: rtl/tu_pkg.sv
package tu_pkg;

    localparam logic [7:0] CODE_BE = 8'hFB;
    localparam logic [7:0] CODE_BS = 8'hBC;
    localparam logic [7:0] CODE_FS = 8'hFE;
    localparam logic [7:0] CODE_FE = 8'hF7;

    typedef enum logic [1:0] {
        MODE_IDLE,
        MODE_DATA,
        MODE_STUFF,
        MODE_CLOSE
    } mode_e;

    typedef enum logic [2:0] {
        SYM_IDLE,
        SYM_DATA,
        SYM_BE,
        SYM_BS,
        SYM_FS,
        SYM_FE,
        SYM_PAD
    } sym_e;

endpackage

// File: rtl/tu_fill_pacer.sv
module tu_fill_pacer #(
    parameter int LEN_W   = 7,
    parameter int FRAC_W  = 16,
    parameter int DEF_CAP = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_open,
    input  logic              unit_open,
    input  logic [LEN_W-1:0]  unit_sent,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [LEN_W-1:0]  cfg_int,
    input  logic [FRAC_W-1:0] cfg_frac,
    output logic [LEN_W-1:0]  quota
);

    localparam int TOT_W = LEN_W + 2;

    typedef struct packed {
        logic [FRAC_W-1:0] phase;
        logic [TOT_W-1:0]  tot;
        logic [LEN_W-1:0]  quota;
    } pacer_t;

    pacer_t st_d, st_q;

    logic [FRAC_W-1:0] base_phase;
    logic [TOT_W-1:0]  left_d;
    logic [TOT_W-1:0]  base_def;
    logic [FRAC_W:0]   acc_d;
    logic [TOT_W-1:0]  tot_new;
    logic [TOT_W-1:0]  cap_d;

    always_comb begin
        st_d       = st_q;
        base_phase = line_open ? '0 : st_q.phase;
        left_d     = st_q.tot - TOT_W'(unit_sent);
        if (line_open) begin
            base_def = '0;
        end else if (left_d > TOT_W'(DEF_CAP)) begin
            base_def = TOT_W'(DEF_CAP);
        end else begin
            base_def = left_d;
        end
        acc_d   = {1'b0, base_phase} + {1'b0, cfg_frac};
        tot_new = TOT_W'(cfg_int) + TOT_W'(acc_d[FRAC_W]) + base_def;
        cap_d   = TOT_W'(cfg_len) - TOT_W'(2);
        if (line_open || unit_open) begin
            st_d.phase = acc_d[FRAC_W-1:0];
            st_d.tot   = tot_new;
            st_d.quota = (tot_new > cap_d) ? LEN_W'(cap_d) : LEN_W'(tot_new);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign quota = st_q.quota;

endmodule

// File: rtl/tu_framer.sv
module tu_framer
    import tu_pkg::*;
#(
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    input  logic             in_sol,
    input  logic             in_eol,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [LEN_W-1:0] quota,
    output logic             in_ready,
    output logic             line_open,
    output logic             unit_open,
    output logic [LEN_W-1:0] unit_sent,
    output sym_e             sym_kind,
    output logic [7:0]       sym_byte,
    output mode_e            mode,
    output logic [LEN_W-1:0] slot
);

    typedef struct packed {
        mode_e            mode;
        logic [LEN_W-1:0] slot;
        logic [LEN_W-1:0] sent;
        sym_e             kind;
        logic [7:0]       data;
    } frame_t;

    frame_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.kind = SYM_IDLE;
        st_d.data = '0;
        in_ready  = 1'b0;
        line_open = 1'b0;
        unit_open = 1'b0;
        unique case (st_q.mode)
            MODE_IDLE: begin
                in_ready = !in_sol;
                if (in_valid && in_sol) begin
                    st_d.kind = SYM_BE;
                    st_d.mode = MODE_DATA;
                    st_d.slot = '0;
                    st_d.sent = '0;
                    line_open = 1'b1;
                end
            end
            MODE_DATA: begin
                in_ready = (st_q.sent < quota);
                if (in_ready && in_valid) begin
                    st_d.kind = SYM_DATA;
                    st_d.data = in_data;
                    st_d.sent = st_q.sent + LEN_W'(1);
                    st_d.slot = st_q.slot + LEN_W'(1);
                    if (in_eol) begin
                        st_d.mode = MODE_CLOSE;
                    end
                end else begin
                    st_d.kind = SYM_FS;
                    st_d.slot = st_q.slot + LEN_W'(1);
                    st_d.mode = MODE_STUFF;
                end
            end
            MODE_STUFF: begin
                if (st_q.slot == cfg_len - LEN_W'(1)) begin
                    st_d.kind = SYM_FE;
                    st_d.mode = MODE_DATA;
                    st_d.slot = '0;
                    st_d.sent = '0;
                    unit_open = 1'b1;
                end else begin
                    st_d.kind = SYM_PAD;
                    st_d.slot = st_q.slot + LEN_W'(1);
                end
            end
            MODE_CLOSE: begin
                st_d.kind = SYM_BS;
                st_d.mode = MODE_IDLE;
                st_d.slot = '0;
                st_d.sent = '0;
            end
            default: begin
                st_d.mode = MODE_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_IDLE, slot: '0, sent: '0, kind: SYM_IDLE, data: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign unit_sent = st_q.sent;
    assign sym_kind  = st_q.kind;
    assign sym_byte  = st_q.data;
    assign mode      = st_q.mode;
    assign slot      = st_q.slot;

endmodule

// File: rtl/tu_sym_encode.sv
module tu_sym_encode
    import tu_pkg::*;
(
    input  sym_e       sym_kind,
    input  logic [7:0] sym_byte,
    output logic [7:0] out_sym,
    output logic       out_is_k
);

    always_comb begin
        out_sym  = 8'h00;
        out_is_k = 1'b1;
        unique case (sym_kind)
            SYM_DATA: begin out_sym = sym_byte; out_is_k = 1'b0; end
            SYM_BE:   out_sym = CODE_BE;
            SYM_BS:   out_sym = CODE_BS;
            SYM_FS:   out_sym = CODE_FS;
            SYM_FE:   out_sym = CODE_FE;
            default:  out_is_k = 1'b0;
        endcase
    end

endmodule

// File: rtl/tu_stuff_packer.sv
module tu_stuff_packer
    import tu_pkg::*;
#(
    parameter int LEN_W   = 7,
    parameter int FRAC_W  = 16,
    parameter int DEF_CAP = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sol,
    input  logic              in_eol,
    input  logic [LEN_W-1:0]  cfg_tu_len,
    input  logic [LEN_W-1:0]  cfg_fill_int,
    input  logic [FRAC_W-1:0] cfg_fill_frac,
    output logic [7:0]        out_sym,
    output logic              out_is_k
);

    logic             fr_line_open;
    logic             fr_unit_open;
    logic [LEN_W-1:0] fr_sent;
    logic [LEN_W-1:0] fr_slot;
    logic [LEN_W-1:0] pc_quota;
    mode_e            fr_mode;
    sym_e             fr_kind;
    logic [7:0]       fr_byte;

    tu_fill_pacer #(
        .LEN_W  (LEN_W),
        .FRAC_W (FRAC_W),
        .DEF_CAP(DEF_CAP)
    ) u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_open(fr_line_open),
        .unit_open(fr_unit_open),
        .unit_sent(fr_sent),
        .cfg_len  (cfg_tu_len),
        .cfg_int  (cfg_fill_int),
        .cfg_frac (cfg_fill_frac),
        .quota    (pc_quota)
    );

    tu_framer #(
        .LEN_W(LEN_W)
    ) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (in_data),
        .in_valid (in_valid),
        .in_sol   (in_sol),
        .in_eol   (in_eol),
        .cfg_len  (cfg_tu_len),
        .quota    (pc_quota),
        .in_ready (in_ready),
        .line_open(fr_line_open),
        .unit_open(fr_unit_open),
        .unit_sent(fr_sent),
        .sym_kind (fr_kind),
        .sym_byte (fr_byte),
        .mode     (fr_mode),
        .slot     (fr_slot)
    );

    tu_sym_encode u_encode (
        .sym_kind(fr_kind),
        .sym_byte(fr_byte),
        .out_sym (out_sym),
        .out_is_k(out_is_k)
    );

endmodule

// File: rtl/tu_stuff_packer_chk.sv
module tu_stuff_packer_chk
    import tu_pkg::*;
#(
    parameter int LEN_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       in_data,
    input logic             in_valid,
    input logic             in_ready,
    input logic [LEN_W-1:0] cfg_tu_len,
    input logic [7:0]       out_sym,
    input logic             out_is_k,
    input mode_e            fr_mode,
    input logic [LEN_W-1:0] fr_slot,
    input logic [LEN_W-1:0] pc_quota
);

    // R5
    data_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && fr_mode == MODE_DATA) |=> (!out_is_k && out_sym == $past(in_data)));

    // R11
    ready_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_mode == MODE_STUFF || fr_mode == MODE_CLOSE) |-> !in_ready);

    // R3
    fe_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_is_k && out_sym == CODE_FE) |-> (fr_slot == '0 && fr_mode == MODE_DATA));

    // R4
    fe_after_stuff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_is_k && out_sym == CODE_FE) |->
        $past((out_is_k && out_sym == CODE_FS) || (!out_is_k && out_sym == 8'h00)));

    // R7
    quota_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_mode == MODE_DATA) |-> (pc_quota <= cfg_tu_len - LEN_W'(2)));

    // R9
    bs_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_is_k && out_sym == CODE_BS) |-> (fr_mode == MODE_IDLE));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_mode == MODE_IDLE && $past(fr_mode == MODE_IDLE)) |-> (!out_is_k && out_sym == 8'h00));

endmodule

bind tu_stuff_packer tu_stuff_packer_chk #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .cfg_tu_len(cfg_tu_len),
    .out_sym   (out_sym),
    .out_is_k  (out_is_k),
    .fr_mode   (fr_mode),
    .fr_slot   (fr_slot),
    .pc_quota  (pc_quota)
);

// File: tb/tu_stuff_packer_tb.sv
module tu_stuff_packer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;

    typedef struct packed {
        int len;
        int fint;
        int ffrac;
        int nsym;
        int seed;
    } vec_t;

    localparam vec_t VECS [0:NVEC-1] = '{
        '{32, 12, 32'h8000, 100, 1},
        '{64, 20, 32'h5555, 150, 2},
        '{40, 38, 32'h4000, 120, 3},
        '{32,  5, 32'hF000,  60, 4},
        '{48,  0, 32'h2000,   3, 5},
        '{32, 12, 32'h8000, 100, 6}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_sol = 1'b0;
    logic        in_eol = 1'b0;
    logic [6:0]  cfg_tu_len = 7'd32;
    logic [6:0]  cfg_fill_int = '0;
    logic [15:0] cfg_fill_frac = '0;
    logic [7:0]  out_sym;
    logic        out_is_k;

    int n_cmp = 0;
    int n_bad = 0;
    int unit_cnt [0:255];
    int n_units;
    int last_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    tu_stuff_packer u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_data      (in_data),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_sol       (in_sol),
        .in_eol       (in_eol),
        .cfg_tu_len   (cfg_tu_len),
        .cfg_fill_int (cfg_fill_int),
        .cfg_fill_frac(cfg_fill_frac),
        .out_sym      (out_sym),
        .out_is_k     (out_is_k)
    );

    function automatic logic [7:0] src_byte(input int idx, input int seed);
        return 8'((idx * 37 + seed * 11) & 255);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic run_line(input int len, input int fint, input int ffrac,
                            input int nsym, input int seed, input int stall_at);
        int idx = 0;
        int pst = 0;
        int slot = 0;
        int cnt = 0;
        int cyc = 0;
        bit hs = 1'b0;
        bit stalled = 1'b0;
        cfg_tu_len    = 7'(len);
        cfg_fill_int  = 7'(fint);
        cfg_fill_frac = 16'(ffrac);
        n_units  = 0;
        last_cnt = -1;
        while (pst != 3 && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            case (pst)
                0: begin
                    if (out_is_k && out_sym == 8'hFB) begin
                        check(cyc == 2, "R2 BE one cycle after line start", cyc, 2);
                        pst = 1; slot = 0; cnt = 0;
                    end else begin
                        check(!out_is_k && out_sym == 8'h00, "R1 idle symbol", {23'd0, out_is_k, out_sym}, 0);
                    end
                end
                1: begin
                    if (!out_is_k) begin
                        check(out_sym == src_byte(idx, seed), "R5 payload order", out_sym, src_byte(idx, seed));
                        cnt++; slot++;
                        check(cnt <= len - 2, "R7 payload per unit bound", cnt, len - 2);
                    end else if (out_sym == 8'hFE) begin
                        slot++; pst = 2;
                    end else if (out_sym == 8'hBC) begin
                        last_cnt = cnt; pst = 3;
                    end else begin
                        check(1'b0, "R4 unexpected control in payload part", out_sym, 8'hFE);
                    end
                end
                2: begin
                    if (slot == len - 1) begin
                        check(out_is_k && out_sym == 8'hF7, "R3 FE in last slot", {23'd0, out_is_k, out_sym}, 9'h1F7);
                        unit_cnt[n_units] = cnt;
                        n_units++;
                        cnt = 0; slot = 0; pst = 1;
                    end else begin
                        check(!out_is_k && out_sym == 8'h00, "R4 stuffing zero", {23'd0, out_is_k, out_sym}, 0);
                        slot++;
                    end
                end
                default: ;
            endcase
            if (hs) idx++;
            in_sol   = (idx == 0);
            in_eol   = (idx == nsym - 1);
            in_data  = src_byte(idx, seed);
            in_valid = (idx < nsym) && !(idx == stall_at && !stalled);
            #1;
            hs = in_valid && in_ready;
            if (idx == stall_at && !stalled && in_ready) stalled = 1'b1;
        end
        check(pst == 3, "R9 line closed by BS", pst, 3);
        in_valid = 1'b0;
        in_sol   = 1'b0;
        in_eol   = 1'b0;
    endtask

    task automatic check_model(input int len, input int fint, input int ffrac, input int nsym);
        longint phase = 0;
        int owed = 0;
        int total = 0;
        int q = 0;
        for (int k = 0; k <= n_units; k++) begin
            longint s = phase + ffrac;
            int carry = int'(s >> 16);
            int tot;
            phase = s & 64'hFFFF;
            tot = fint + carry + owed;
            q = (tot > len - 2) ? len - 2 : tot;
            owed = (tot - q > 64) ? 64 : tot - q;
            if (k < n_units) begin
                if (fint + 1 > len - 2)
                    check(unit_cnt[k] == q, "R7 clamped unit count", unit_cnt[k], q);
                else
                    check(unit_cnt[k] == q, "R6 fractional unit count", unit_cnt[k], q);
                total += unit_cnt[k];
            end
        end
        check(last_cnt >= 1 && last_cnt <= q, "R9 last unit cut short", last_cnt, q);
        check(total + last_cnt == nsym, "R9 all payload delivered", total + last_cnt, nsym);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check(!out_is_k && out_sym == 8'h00, "R10 output in reset", {23'd0, out_is_k, out_sym}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_is_k && out_sym == 8'h00, "R10 output after reset", {23'd0, out_is_k, out_sym}, 0);
        check(in_ready == 1'b1, "R10 ready after reset", in_ready, 1);

        // R1: symbols without line start are dropped while idle
        in_valid = 1'b1;
        in_data  = 8'hAA;
        for (int i = 0; i < 3; i++) begin
            #1;
            check(in_ready == 1'b1, "R1 idle accepts stray symbol", in_ready, 1);
            @(negedge clk);
            check(!out_is_k && out_sym == 8'h00, "R1 stray symbol not emitted", {23'd0, out_is_k, out_sym}, 0);
        end
        in_valid = 1'b0;
        @(negedge clk);

        // Table of line scenarios (R6, R7, R9 phase restart via repeated vector)
        for (int v = 0; v < NVEC; v++) begin
            run_line(VECS[v].len, VECS[v].fint, VECS[v].ffrac, VECS[v].nsym, VECS[v].seed, -1);
            check_model(VECS[v].len, VECS[v].fint, VECS[v].ffrac, VECS[v].nsym);
            repeat (2) @(negedge clk);
        end

        // R8: source stall in first unit, deficit carried forward
        run_line(32, 10, 0, 40, 7, 4);
        check(n_units == 3, "R8 complete units", n_units, 3);
        check(unit_cnt[0] == 4, "R8 stalled unit count", unit_cnt[0], 4);
        check(unit_cnt[1] == 16, "R8 deficit added to next unit", unit_cnt[1], 16);
        check(unit_cnt[2] == 10, "R8 back to base allowance", unit_cnt[2], 10);
        check(last_cnt == 10, "R9 last unit after stall", last_cnt, 10);

        // R11: ready low while stuffing (allowance 0 unit)
        repeat (2) @(negedge clk);
        cfg_tu_len = 7'd32; cfg_fill_int = 7'd0; cfg_fill_frac = 16'd0;
        in_valid = 1'b1; in_sol = 1'b1; in_eol = 1'b1; in_data = 8'h55;
        @(negedge clk);
        in_sol = 1'b0;
        check(out_is_k && out_sym == 8'hFB, "R2 BE emitted", {23'd0, out_is_k, out_sym}, 9'h1FB);
        #1;
        check(in_ready == 1'b0, "R11 no room in zero-allowance unit", in_ready, 0);
        @(negedge clk);
        check(out_is_k && out_sym == 8'hFE, "R4 FS in slot zero", {23'd0, out_is_k, out_sym}, 9'h1FE);
        check(in_ready == 1'b0, "R11 ready low while stuffing", in_ready, 0);
        in_valid = 1'b0; in_eol = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_is_k && out_sym == 8'h00, "R10 idle after second reset", {23'd0, out_is_k, out_sym}, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule